// File: doc/BRIEF.md
# Standby bus wake-up pattern detector

While a bus transceiver sits in its low-power standby state, this block watches a bus-dominant indication that is already synchronized to its clock. It looks for a three-phase wake-up pattern: a long dominant phase, then a recessive phase, then a second dominant phase. All three phases must finish inside one timeout window. This rule keeps a bus that is stuck dominant, whether from a short or a faulty node, from ever waking the system. When the pattern is recognized, the block raises a wake flag and from then on mirrors the bus level on its receive-data output. Each level change reaches that output only after a programmable reporting delay.

All durations are parameters counted in clock cycles. `FILT1_CYC` is the minimum for the first dominant phase. `FILT2_CYC` is the minimum for the recessive phase and for the second dominant phase. `WINDOW_CYC` is the timeout window. `TOGGLE_CYC` is the reporting delay. The parameters must satisfy `FILT2_CYC >= 1`, `TOGGLE_CYC >= 1` and `FILT1_CYC < WINDOW_CYC`. When the standby flag is low, the block is held idle and the output rests high.

Top module: `wake_pattern_detect`

## Requirements
- R1: After reset, `rxd` is 1 and `wake_detected` is 0.
- R2: Phase one needs more than `FILT1_CYC` consecutive dominant samples. A dominant run of exactly `FILT1_CYC` samples or fewer returns the detector to idle.
- R3: Phase two needs more than `FILT2_CYC` consecutive recessive samples after phase one.
- R4: Phase three is a dominant run following phase two. `wake_detected` rises at the clock edge that samples the (`FILT2_CYC`+1)-th dominant sample of phase three. A recessive sample before that edge returns the detector to idle.
- R5: Samples are numbered from 1, starting at the first dominant sample seen while idle. A wake happens only if the completing sample has a number no greater than `WINDOW_CYC`. If the window runs out first, the detector ignores the bus until it samples a recessive level, and then re-arms.
- R6: If the phase-two recessive run is too short, the dominant sample that ends it starts a new phase one with a fresh window.
- R7: A bus that stays dominant, for any length of time, never raises `wake_detected`.
- R8: While `wake_detected` is 0, `rxd` is 1.
- R9: Once awake, `rxd` follows the inverse of `bus_dom` (dominant = 0, recessive = 1). `rxd` changes at the `TOGGLE_CYC`-th consecutive edge at which the awake detector samples a bus level opposite to `rxd`. A shorter excursion leaves `rxd` unchanged.
- R10: At the first clock edge that samples `standby` = 0, `wake_detected` clears to 0 and `rxd` returns to 1.
- R11: `wake_detected` stays 1 for as long as `standby` stays 1, whatever the bus does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | 1 while the transceiver is in standby |
| bus_dom | input | 1 | Synchronized bus level, 1 = dominant |
| rxd | output | 1 | Receive-data report, 0 = dominant |
| wake_detected | output | 1 | Wake-up pattern recognized |

## Verification
In one cycle the window can run out on the same sample that completes phase three, so the wake decision and the expiry decision fall together. The bench sweeps every combination of first-phase and recessive-phase lengths over a small configuration. This sweep includes the cases where the completing sample number equals `WINDOW_CYC` exactly, and also the cases one sample past it. For each case the bench compares the observed wake cycle with the sample number computed from the lengths. A wake on exactly the last window sample must be reported, and one sample later must not.

// File: rtl/wake_pattern_detect.sv
module wake_pattern_detect #(
  parameter int FILT1_CYC  = 40,
  parameter int FILT2_CYC  = 6,
  parameter int WINDOW_CYC = 800,
  parameter int TOGGLE_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic standby,
  input  logic bus_dom,
  output logic rxd,
  output logic wake_detected
);
  localparam int CW = $clog2(WINDOW_CYC + 2);
  localparam int TW = $clog2(TOGGLE_CYC + 1);
  localparam logic [CW-1:0] F1 = CW'(FILT1_CYC);
  localparam logic [CW-1:0] F2 = CW'(FILT2_CYC);
  localparam logic [CW-1:0] WL = CW'(WINDOW_CYC);
  localparam logic [TW-1:0] TG_LAST = TW'(TOGGLE_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_PH1, S_PH2, S_PH3, S_HOLD, S_AWAKE} st_t;

  st_t st_q, st_n;
  logic [CW-1:0] run_q, run_n, win_q, win_n;
  logic [TW-1:0] tg_q;

  wire [CW-1:0] run_inc = run_q + 1'b1;
  wire [CW-1:0] win_inc = win_q + 1'b1;
  wire          win_end = win_inc >= WL;

  assign wake_detected = (st_q == S_AWAKE);

  always_comb begin
    st_n  = st_q;
    run_n = run_inc;
    win_n = win_inc;
    case (st_q)
      S_IDLE: begin
        run_n = '0;
        win_n = '0;
        if (bus_dom) begin
          st_n  = S_PH1;
          run_n = CW'(1);
          win_n = CW'(1);
        end
      end
      S_PH1: begin
        if (!bus_dom && run_q <= F1) st_n = S_IDLE;
        else if (win_end)            st_n = S_HOLD;
        else if (!bus_dom) begin
          st_n  = S_PH2;
          run_n = CW'(1);
        end
      end
      S_PH2: begin
        if (bus_dom && run_q <= F2) begin
          st_n  = S_PH1;
          run_n = CW'(1);
          win_n = CW'(1);
        end else if (win_end) st_n = S_HOLD;
        else if (bus_dom) begin
          st_n  = S_PH3;
          run_n = CW'(1);
        end
      end
      S_PH3: begin
        if (!bus_dom)          st_n = S_IDLE;
        else if (run_inc > F2) st_n = S_AWAKE;
        else if (win_end)      st_n = S_HOLD;
      end
      S_HOLD: begin
        run_n = '0;
        win_n = '0;
        if (!bus_dom) st_n = S_IDLE;
      end
      default: begin
        run_n = '0;
        win_n = '0;
      end
    endcase
    if (!standby) begin
      st_n  = S_IDLE;
      run_n = '0;
      win_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      run_q <= '0;
      win_q <= '0;
    end else begin
      st_q  <= st_n;
      run_q <= run_n;
      win_q <= win_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd  <= 1'b1;
      tg_q <= '0;
    end else if (!standby || st_q != S_AWAKE) begin
      rxd  <= 1'b1;
      tg_q <= '0;
    end else if ((!bus_dom) != rxd) begin
      if (tg_q == TG_LAST) begin
        rxd  <= !bus_dom;
        tg_q <= '0;
      end else begin
        tg_q <= tg_q + 1'b1;
      end
    end else begin
      tg_q <= '0;
    end
  end
endmodule

// File: rtl/wake_pattern_chk.sv
module wake_pattern_chk #(
  parameter int FILT2_CYC = 6
) (
  input logic clk,
  input logic rst_n,
  input logic standby,
  input logic bus_dom,
  input logic rxd,
  input logic wake_detected
);
  localparam int DW = $clog2(FILT2_CYC + 3);
  localparam logic [DW-1:0] CAP = DW'(FILT2_CYC + 2);
  localparam logic [DW-1:0] HIT = DW'(FILT2_CYC + 1);

  logic [DW-1:0] dom_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               dom_run <= '0;
    else if (!bus_dom)        dom_run <= '0;
    else if (dom_run != CAP)  dom_run <= dom_run + 1'b1;
  end

  // R10
  standby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !standby |=> (!wake_detected && rxd));

  // R11
  wake_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && wake_detected) |=> wake_detected);

  // R8
  rxd_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_detected |-> rxd);

  // R4
  wake_run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_detected) |-> (dom_run == HIT && $past(standby)));

  // R9
  rxd_fall_dom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxd) |-> ($past(bus_dom) && wake_detected));

  // R9
  rxd_rise_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rxd) && $past(standby)) |-> !$past(bus_dom));
endmodule

bind wake_pattern_detect wake_pattern_chk #(.FILT2_CYC(FILT2_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .bus_dom(bus_dom),
  .rxd(rxd), .wake_detected(wake_detected)
);

// File: tb/sim_wake_pattern_detect.sv
module sim_wake_pattern_detect;
  localparam int F1 = 3, F2 = 2, TO = 16, TG = 3;

  logic clk = 1'b0, rst_n = 1'b0, standby = 1'b0, bus_dom = 1'b0;
  logic rxd, wake_detected;
  int total = 0, bad = 0;
  int seg[8];
  int nseg;
  int k, fw, fl, fh, rel_start;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wake_pattern_detect #(.FILT1_CYC(F1), .FILT2_CYC(F2), .WINDOW_CYC(TO), .TOGGLE_CYC(TG)) u0 (
    .clk(clk), .rst_n(rst_n), .standby(standby), .bus_dom(bus_dom),
    .rxd(rxd), .wake_detected(wake_detected));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic b);
    bus_dom = b;
    @(posedge clk);
    @(negedge clk);
    k++;
    if (wake_detected && fw < 0) fw = k;
    if (!rxd && fl < 0) fl = k;
    if (fl >= 0 && rxd && fh < 0) fh = k;
  endtask

  task automatic clear_det;
    standby = 1'b0;
    step(1'b0); step(1'b0);
    standby = 1'b1;
    step(1'b0); step(1'b0);
  endtask

  task automatic play(input int rel);
    k = 0; fw = -1; fl = -1; fh = -1;
    for (int i = 0; i < nseg; i++)
      for (int j = 0; j < seg[i]; j++) step(i % 2 == 0);
    rel_start = k + 1;
    for (int j = 0; j < rel; j++) step(1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rxd == 1'b1, "R1 rxd", rxd, 1);
    chk(wake_detected == 1'b0, "R1 wake", wake_detected, 0);
    standby = 1'b1;
    step(1'b0); step(1'b0);

    for (int d1 = 1; d1 <= TO + 1; d1++) begin
      for (int r = 1; r <= TO; r++) begin
        int w;
        bit ok_w;
        string tag;
        clear_det();
        seg[0] = d1; seg[1] = r; seg[2] = TO + 8; nseg = 3;
        play(TG + 2);
        w = d1 + r + F2 + 1;
        ok_w = (d1 > F1) && (r > F2) && (w <= TO);
        if (d1 <= F1) tag = "R2";
        else if (r <= F2) tag = "R3";
        else if (w > TO) tag = "R5";
        else tag = "R4";
        chk(fw == (ok_w ? w : -1), tag, fw, ok_w ? w : -1);
        if (ok_w) begin
          chk(fl == w + TG, "R9 fall", fl, w + TG);
          chk(fh == rel_start + TG - 1, "R9 rise", fh, rel_start + TG - 1);
          chk(wake_detected == 1'b1, "R11", wake_detected, 1);
        end else begin
          chk(fl == -1, "R8", fl, -1);
        end
      end
    end

    // R7: permanent dominant
    clear_det();
    seg[0] = 3 * TO + 5; nseg = 1;
    play(0);
    chk(fw == -1, "R7 wake", fw, -1);
    chk(fl == -1 && rxd, "R7 rxd", fl, -1);

    // R6: short recessive restarts with a fresh window
    clear_det();
    seg[0] = 8; seg[1] = 1; seg[2] = 4; seg[3] = 3; seg[4] = 20; nseg = 5;
    play(0);
    chk(fw == 19, "R6", fw, 19);

    // R5: after expiry, re-arm only once recessive
    clear_det();
    seg[0] = 40; seg[1] = 3; seg[2] = 4; seg[3] = 3; seg[4] = 20; nseg = 5;
    play(0);
    chk(fw == 53, "R5 rearm", fw, 53);

    // R9: short recessive excursion after wake is ignored
    clear_det();
    seg[0] = 4; seg[1] = 3; seg[2] = 12; nseg = 3;
    play(0);
    chk(fl == 10 + TG, "R9 wake fall", fl, 10 + TG);
    for (int j = 0; j < TG - 1; j++) step(1'b0);
    for (int j = 0; j < 4; j++) step(1'b1);
    chk(fh == -1 && !rxd, "R9 glitch", fh, -1);

    // R10: leaving standby clears at once
    standby = 1'b0;
    step(1'b1);
    chk(wake_detected == 1'b0, "R10 wake", wake_detected, 0);
    chk(rxd == 1'b1, "R10 rxd", rxd, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule